// File: doc/BRIEF.md
# Unaligned Access Fragment Splitter

The block takes one word (2-byte) or longword (4-byte) access at any byte offset. It breaks the access into one or two fragments, and each fragment stays inside a single aligned longword. For a read, it merges the fragment data back into one right-justified result. For a write, it spreads the right-justified write data across the fragments. The caller supplies the address of the following aligned longword, so any translation or page-crossing lookup stays outside this block.

Each fragment is routed by the most significant address bit:
- **Local memory region (MSB = 0).** The block owns a byte-lane longword RAM. It shifts and masks read data itself. It writes only the byte lanes the fragment covers, so no read-modify-write is needed.
- **External region (MSB = 1).** The block presents the fragment on a fragment port as an address with byte offset, a length of 1 to 4 bytes, and right-justified data. The port is built so that a read never touches more bytes than the access asks for.

The block takes one access at a time. A one-fragment access completes three clock edges after acceptance. A split access completes four clock edges after acceptance, because the second fragment issues while the first fragment's data is returning.

Top module: `uas_splitter`

## Requirements
- R1: After reset, req_ready is 1, and resp_valid and frag_valid are 0.
- R2: Let n = 2 (req_long = 0) or n = 4 (req_long = 1), and let bo = req_addr[1:0].
  - If bo + n <= 4, the access is one fragment at req_addr of length n.
  - Otherwise it is two fragments. The first is at req_addr with length 4 - bo. The second is at req_next with bits [1:0] cleared, with length bo + n - 4.
  - The first fragment is issued in the cycle before the second.
- R3: A read returns resp_rdata = D1 | (D2 << 8*(4 - bo)), where D1 and D2 are the fragment data masked to their lengths. The result is D1 alone when the access is not split. Bytes that the external port returns above a fragment's length are discarded.
- R4: For a write, the first fragment carries req_wdata masked to its length. The second fragment carries req_wdata shifted right by 8*(first length), masked to its length. On the fragment port, frag_wdata bits above 8*frag_len are 0.
- R5: A fragment whose address MSB is 0 goes to the local RAM word addr[AW-2:2]. A read returns (word >> 8*off) masked to the length. A write changes only bytes off to off+len-1 of that word. Such a fragment never appears on the fragment port.
- R6: A fragment whose address MSB is 1 appears on the fragment port for exactly one cycle with frag_valid = 1. Its read data is taken from frag_rdata in the following cycle.
- R7: resp_valid is a one-cycle pulse. It comes 3 clock edges after the accepting edge for a one-fragment access, and 4 edges after for a split access. req_ready is 0 from the accepting edge until resp_valid rises. resp_rdata is 0 for writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request |
| req_ready | output | 1 | Block idle, request accepted on this edge |
| req_write | input | 1 | 1 = write, 0 = read |
| req_long | input | 1 | 1 = longword, 0 = word |
| req_addr | input | AW | Byte address of the access |
| req_next | input | AW | Address of the following longword (low bits ignored) |
| req_wdata | input | 32 | Right-justified write data |
| resp_valid | output | 1 | Access complete pulse |
| resp_rdata | output | 32 | Merged right-justified read data |
| frag_valid | output | 1 | External fragment present |
| frag_write | output | 1 | External fragment is a write |
| frag_addr | output | AW | Fragment byte address |
| frag_len | output | 3 | Fragment length in bytes, 1 to 4 |
| frag_wdata | output | 32 | Right-justified fragment write data |
| frag_rdata | input | 32 | Fragment read data, valid the cycle after frag_valid |

## Verification
In a split access, two things can happen in the same cycle. The second fragment is issued, and the first fragment's data returns and is captured into the merge register. When the two fragments fall in different regions, a local RAM read completes in the same cycle that the external port carries a fragment.

The bench provokes these cases by sweeping every offset and both sizes over every longword. It chooses the supplied next address so that some second fragments cross from the RAM into the external region and back.

The bench then judges three things:
- the merged read value against a byte-level reference model;
- the logged fragment sequence, checking order, address, length and clean data;
- a final read-back of all storage, which shows that no byte outside a fragment was disturbed.

// File: rtl/uas_pkg.sv
package uas_pkg;
  localparam int DW = 32;

  typedef logic [2:0] flen_t;

  function automatic logic [DW-1:0] len_mask(input flen_t n);
    case (n)
      3'd1:    return 32'h0000_00FF;
      3'd2:    return 32'h0000_FFFF;
      3'd3:    return 32'h00FF_FFFF;
      3'd4:    return 32'hFFFF_FFFF;
      default: return 32'h0000_0000;
    endcase
  endfunction

  function automatic logic [3:0] lane_sel(input flen_t n, input logic [1:0] off);
    logic [3:0] base;
    case (n)
      3'd1:    base = 4'b0001;
      3'd2:    base = 4'b0011;
      3'd3:    base = 4'b0111;
      3'd4:    base = 4'b1111;
      default: base = 4'b0000;
    endcase
    return base << off;
  endfunction
endpackage

// File: rtl/uas_plan.sv
module uas_plan
  import uas_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic [AW-1:0] addr,
  input  logic [AW-1:0] next,
  input  logic          is_long,
  input  logic [DW-1:0] wdata,
  output logic          split,
  output flen_t         len1,
  output flen_t         len2,
  output logic [AW-1:0] addr2,
  output logic [DW-1:0] wdata1,
  output logic [DW-1:0] wdata2,
  output logic [4:0]    sh2
);
  flen_t nbytes;
  flen_t span;

  always_comb begin
    nbytes = is_long ? 3'd4 : 3'd2;
    span   = {1'b0, addr[1:0]} + nbytes;
    split  = (span > 3'd4);
    len1   = split ? (3'd4 - {1'b0, addr[1:0]}) : nbytes;
    len2   = split ? (span - 3'd4) : 3'd0;
    addr2  = next & ~(AW'(3));
    sh2    = {len1[1:0], 3'b000};
    wdata1 = wdata & len_mask(len1);
    wdata2 = (wdata >> sh2) & len_mask(len2);
  end
endmodule

// File: rtl/uas_bram.sv
module uas_bram #(
  parameter int WORDS = 128,
  localparam int IW = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          en,
  input  logic          we,
  input  logic [IW-1:0] idx,
  input  logic [3:0]    be,
  input  logic [31:0]   wdata,
  output logic [31:0]   q
);
  for (genvar g = 0; g < 4; g++) begin : g_lane
    logic [7:0] lane [WORDS];
    always_ff @(posedge clk) begin
      if (en) begin
        if (we && be[g]) lane[idx] <= wdata[8*g +: 8];
        q[8*g +: 8] <= lane[idx];
      end
    end
  end
endmodule

// File: rtl/uas_splitter.sv
module uas_splitter
  import uas_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic          req_long,
  input  logic [AW-1:0] req_addr,
  input  logic [AW-1:0] req_next,
  input  logic [31:0]   req_wdata,
  output logic          resp_valid,
  output logic [31:0]   resp_rdata,
  output logic          frag_valid,
  output logic          frag_write,
  output logic [AW-1:0] frag_addr,
  output logic [2:0]    frag_len,
  output logic [31:0]   frag_wdata,
  input  logic [31:0]   frag_rdata
);
  localparam int IW    = AW - 3;
  localparam int WORDS = 2 ** IW;

  // split plan for the incoming request
  logic          p_split;
  flen_t         p_len1, p_len2;
  logic [AW-1:0] p_addr2;
  logic [DW-1:0] p_wd1, p_wd2;
  logic [4:0]    p_sh2;

  uas_plan #(.AW(AW)) plan_i (
    .addr(req_addr), .next(req_next), .is_long(req_long), .wdata(req_wdata),
    .split(p_split), .len1(p_len1), .len2(p_len2), .addr2(p_addr2),
    .wdata1(p_wd1), .wdata2(p_wd2), .sh2(p_sh2)
  );

  logic accept;
  logic busy;
  logic w_q;
  logic [4:0] sh_q;

  // held second fragment
  logic          have2;
  logic [AW-1:0] h_addr;
  flen_t         h_len;
  logic [DW-1:0] h_wdata;

  // issue stage
  logic          iss_v, iss_mem, iss_second, iss_last;
  logic [AW-1:0] iss_addr;
  flen_t         iss_len;
  logic [DW-1:0] iss_wdata;

  // return stage
  logic          ret_v, ret_mem, ret_second, ret_last;
  logic [1:0]    ret_off;
  flen_t         ret_len;
  logic [DW-1:0] acc;

  logic [DW-1:0] ram_q;
  logic [DW-1:0] ret_data;
  logic [DW-1:0] merged;

  assign req_ready = !busy;
  assign accept    = req_valid && !busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy       <= 1'b0;
      w_q        <= 1'b0;
      sh_q       <= '0;
      have2      <= 1'b0;
      h_addr     <= '0;
      h_len      <= '0;
      h_wdata    <= '0;
      iss_v      <= 1'b0;
      iss_mem    <= 1'b0;
      iss_second <= 1'b0;
      iss_last   <= 1'b0;
      iss_addr   <= '0;
      iss_len    <= '0;
      iss_wdata  <= '0;
    end else if (accept) begin
      busy       <= 1'b1;
      w_q        <= req_write;
      sh_q       <= p_sh2;
      have2      <= p_split;
      h_addr     <= p_addr2;
      h_len      <= p_len2;
      h_wdata    <= p_wd2;
      iss_v      <= 1'b1;
      iss_mem    <= !req_addr[AW-1];
      iss_second <= 1'b0;
      iss_last   <= !p_split;
      iss_addr   <= req_addr;
      iss_len    <= p_len1;
      iss_wdata  <= p_wd1;
    end else begin
      if (have2) begin
        have2      <= 1'b0;
        iss_v      <= 1'b1;
        iss_mem    <= !h_addr[AW-1];
        iss_second <= 1'b1;
        iss_last   <= 1'b1;
        iss_addr   <= h_addr;
        iss_len    <= h_len;
        iss_wdata  <= h_wdata;
      end else begin
        iss_v <= 1'b0;
      end
      if (ret_v && ret_last) busy <= 1'b0;
    end
  end

  // external fragment port, driven straight from the issue registers
  assign frag_valid = iss_v && !iss_mem;
  assign frag_write = w_q;
  assign frag_addr  = iss_addr;
  assign frag_len   = iss_len;
  assign frag_wdata = iss_wdata;

  uas_bram #(.WORDS(WORDS)) ram_i (
    .clk(clk),
    .en(iss_v && iss_mem),
    .we(w_q),
    .idx(iss_addr[AW-2:2]),
    .be(lane_sel(iss_len, iss_addr[1:0])),
    .wdata(iss_wdata << {iss_addr[1:0], 3'b000}),
    .q(ram_q)
  );

  always_comb begin
    ret_data = (ret_mem ? (ram_q >> {ret_off, 3'b000}) : frag_rdata) & len_mask(ret_len);
    merged   = ret_second ? (acc | (ret_data << sh_q)) : ret_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ret_v      <= 1'b0;
      ret_mem    <= 1'b0;
      ret_second <= 1'b0;
      ret_last   <= 1'b0;
      ret_off    <= '0;
      ret_len    <= '0;
      acc        <= '0;
      resp_valid <= 1'b0;
      resp_rdata <= '0;
    end else begin
      ret_v      <= iss_v;
      ret_mem    <= iss_mem;
      ret_second <= iss_second;
      ret_last   <= iss_last;
      ret_off    <= iss_addr[1:0];
      ret_len    <= iss_len;
      resp_valid <= 1'b0;
      if (ret_v) begin
        acc <= merged;
        if (ret_last) begin
          resp_valid <= 1'b1;
          resp_rdata <= w_q ? '0 : merged;
        end
      end
    end
  end
endmodule

// File: rtl/uas_splitter_chk.sv
module uas_splitter_chk
  import uas_pkg::*;
#(
  parameter int AW = 10
) (
  input logic          clk,
  input logic          rst,
  input logic          req_valid,
  input logic          req_ready,
  input logic          resp_valid,
  input logic          frag_valid,
  input logic          frag_write,
  input logic [AW-1:0] frag_addr,
  input logic [2:0]    frag_len,
  input logic [31:0]   frag_wdata
);
  // R7: completion is a single-cycle pulse
  a_r7_resp_pulse: assert property (@(posedge clk) disable iff (rst)
    resp_valid |=> !resp_valid);

  // R7: an accepted request makes the block busy and cannot complete at once
  a_r7_busy_after_accept: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> (!req_ready && !resp_valid));

  // R6: fragments only appear while an access is in flight
  a_r6_frag_while_busy: assert property (@(posedge clk) disable iff (rst)
    frag_valid |-> !req_ready);

  // R2: a fragment has 1 to 4 bytes and stays inside one longword
  a_r2_frag_fits: assert property (@(posedge clk) disable iff (rst)
    frag_valid |-> (frag_len != 3'd0 && ({2'b00, frag_addr[1:0]} + {1'b0, frag_len}) <= 4'd4));

  // R2: back-to-back fragments: the later one starts on a longword boundary
  a_r2_second_aligned: assert property (@(posedge clk) disable iff (rst)
    (frag_valid && $past(frag_valid)) |-> (frag_addr[1:0] == 2'b00));

  // R4: write data above the fragment length is zero
  a_r4_wdata_clean: assert property (@(posedge clk) disable iff (rst)
    (frag_valid && frag_write) |-> ((frag_wdata & ~len_mask(frag_len)) == 32'h0));
endmodule

bind uas_splitter uas_splitter_chk #(.AW(AW)) chk_i (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .resp_valid(resp_valid), .frag_valid(frag_valid), .frag_write(frag_write),
  .frag_addr(frag_addr), .frag_len(frag_len), .frag_wdata(frag_wdata)
);

// File: tb/uas_splitter_tb.sv
module uas_splitter_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam int NWORDS = 64;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic          req_write = 1'b0;
  logic          req_long = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [AW-1:0] req_next = '0;
  logic [31:0]   req_wdata = '0;
  logic          resp_valid;
  logic [31:0]   resp_rdata;
  logic          frag_valid;
  logic          frag_write;
  logic [AW-1:0] frag_addr;
  logic [2:0]    frag_len;
  logic [31:0]   frag_wdata;
  logic [31:0]   frag_rdata = '0;

  int errs = 0;
  int checks = 0;
  int cyc = 0;
  bit done = 0;

  logic [7:0]    exp_mem [256];
  logic [7:0]    ext_mem [256];
  logic [AW-1:0] log_addr [4];
  logic [2:0]    log_len [4];
  logic          log_w [4];
  logic [31:0]   log_wd [4];
  int            log_n = 0;

  uas_splitter #(.AW(AW)) dut_i (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  // external responder: one-cycle read latency, filler above the length
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (frag_valid) begin
      if (log_n < 4) begin
        log_addr[log_n] = frag_addr;
        log_len[log_n]  = frag_len;
        log_w[log_n]    = frag_write;
        log_wd[log_n]   = frag_wdata;
      end
      log_n = log_n + 1;
      if (frag_write) begin
        for (int j = 0; j < 4; j++)
          if (j < int'(frag_len)) ext_mem[frag_addr + AW'(j)] = frag_wdata[8*j +: 8];
      end else begin
        logic [31:0] d;
        for (int j = 0; j < 4; j++)
          d[8*j +: 8] = (j < int'(frag_len)) ? ext_mem[frag_addr + AW'(j)] : 8'hC3;
        frag_rdata <= d;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] got, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: got %h exp %h", req, what, got, expv);
    end
  endtask

  task automatic access(input bit w, input bit lng, input logic [AW-1:0] a,
                        input logic [AW-1:0] nx, input logic [31:0] wd);
    int bo, n, l1, l2, k, ne;
    bit split;
    logic [AW-1:0] a2;
    logic [AW-1:0] pos [4];
    logic [31:0] expv;
    logic [AW-1:0] e_addr [2];
    int e_len [2];
    logic [31:0] e_wd [2];
    bo = int'(a[1:0]);
    n = lng ? 4 : 2;
    split = (bo + n) > 4;
    l1 = split ? 4 - bo : n;
    l2 = split ? bo + n - 4 : 0;
    a2 = nx & ~(AW'(3));
    for (int i = 0; i < 4; i++)
      pos[i] = (bo + i < 4) ? a + AW'(i) : a2 + AW'(bo + i - 4);
    expv = '0;
    for (int i = 0; i < n; i++) begin
      if (w) exp_mem[pos[i]] = wd[8*i +: 8];
      expv[8*i +: 8] = exp_mem[pos[i]];
    end
    ne = 0;
    if (a[AW-1]) begin
      e_addr[ne] = a; e_len[ne] = l1; e_wd[ne] = wd & ((l1 == 4) ? 32'hFFFF_FFFF : ((32'h1 << (8*l1)) - 1)); ne++;
    end
    if (split && a2[AW-1]) begin
      e_addr[ne] = a2; e_len[ne] = l2; e_wd[ne] = (wd >> (8*l1)) & ((32'h1 << (8*l2)) - 1); ne++;
    end
    log_n = 0;
    @(negedge clk);
    req_valid = 1; req_write = w; req_long = lng; req_addr = a; req_next = nx; req_wdata = wd;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    k = 1;
    while (!resp_valid && k < 20) begin
      @(negedge clk);
      k++;
    end
    chk(k == (split ? 4 : 3), "R7", $sformatf("latency a=%h long=%0d", a, lng), k, split ? 4 : 3);
    if (!w) chk(resp_rdata == expv, "R3", $sformatf("read a=%h nx=%h long=%0d", a, nx, lng), resp_rdata, expv);
    else chk(resp_rdata == 32'h0, "R7", "write response data", resp_rdata, 0);
    chk(log_n == ne, split ? "R2" : "R5", $sformatf("external fragment count a=%h nx=%h", a, nx), log_n, ne);
    if (log_n == ne) begin
      for (int f = 0; f < ne; f++) begin
        chk(log_addr[f] == e_addr[f], "R2", $sformatf("fragment %0d address", f), 32'(log_addr[f]), 32'(e_addr[f]));
        chk(int'(log_len[f]) == e_len[f], "R2", $sformatf("fragment %0d length", f), 32'(log_len[f]), e_len[f]);
        chk(log_w[f] == w, "R6", "fragment direction", 32'(log_w[f]), 32'(w));
        if (w) chk(log_wd[f] == e_wd[f], "R4", $sformatf("fragment %0d write data", f), log_wd[f], e_wd[f]);
      end
    end
    if (w) begin
      for (int i = 0; i < 4; i++) begin
        logic [AW-1:0] b1, b2;
        b1 = (a & ~(AW'(3))) + AW'(i);
        b2 = a2 + AW'(i);
        if (b1[AW-1]) chk(ext_mem[b1] == exp_mem[b1], "R6", $sformatf("external byte %h", b1), 32'(ext_mem[b1]), 32'(exp_mem[b1]));
        if (split && b2[AW-1]) chk(ext_mem[b2] == exp_mem[b2], "R6", $sformatf("external byte %h", b2), 32'(ext_mem[b2]), 32'(exp_mem[b2]));
      end
    end
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin exp_mem[i] = 8'h00; ext_mem[i] = 8'h00; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1", "ready after reset", 32'(req_ready), 1);
    chk(resp_valid == 1'b0, "R1", "resp_valid after reset", 32'(resp_valid), 0);
    chk(frag_valid == 1'b0, "R1", "frag_valid after reset", 32'(frag_valid), 0);
    // fill every longword with an aligned write (R5 local, R6 external)
    for (int wi = 0; wi < NWORDS; wi++)
      access(1, 1, AW'(wi * 4), AW'(wi * 4 + 4), 32'hA000_0000 ^ (32'(wi) * 32'h0103_0507));
    // sweep offsets and sizes; next word is deliberately non-adjacent (R2, R3, R4)
    for (int wi = 0; wi < NWORDS; wi++)
      for (int lg = 0; lg < 2; lg++)
        for (int bo = 0; bo < 4; bo++) begin
          logic [AW-1:0] a, nx;
          a  = AW'(wi * 4 + bo);
          nx = AW'(((wi * 5 + 7) % NWORDS) * 4 + bo);
          access(1, lg[0], a, nx, 32'h5EED_0000 ^ (32'(wi) << 8) ^ 32'(bo * 17 + lg * 3));
          access(0, lg[0], a, nx, 32'hDEAD_BEEF);
        end
    // full read-back: no byte outside a fragment was disturbed (R5)
    for (int wi = 0; wi < NWORDS; wi++)
      access(0, 1, AW'(wi * 4), AW'(wi * 4 + 4), 32'h0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    wait (cyc >= 150000);
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog: got %0d cycles exp below 150000", cyc);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule